// File: doc/BRIEF.md
# Peak-Current-Mode PWM Controller Core

This block is the digital heart of a peak-current-mode switching regulator. A free-running counter sets the switching period, and the period can be chosen between a minimum and a maximum length (a 5:1 span). At the start of every period the gate-enable output turns on. It turns off at the first of three events: the loop comparator trips, the over-current comparator trips, or the on-time reaches its cap of 80% of the period. Turn-off is decided again in every period, so an over-current event truncates only the pulse in which it occurs.

Both comparator flags are masked for a fixed number of clocks after turn-on, which hides the switching spike at the leading edge. A trip that is still present when the mask lifts ends the pulse at once. A soft-start ramp counter advances once per period. The gate is held off until the ramp passes a low threshold. Above that threshold the on-time cap grows linearly with the ramp and reaches the full 80% at an end level. A supply power-on-reset flag holds the ramp at zero and the gate off. A supply over-voltage flag forces the gate off while it is present. The analog error amplifier, the slope generator and the gate driver sit outside this block.

Top module: `cmpwm_core`

## Requirements
- R1: `cyc_o` pulses high for one clock once every P clocks, where P is `period_i` clamped to the range [PER_MIN, PER_MAX] (defaults 20 and 100). A new `period_i` value applied at a cycle start governs that whole period.
- R2: Within each period the gate-enable output is high for one contiguous run of W clocks, starting in the same clock as the `cyc_o` pulse (W may be zero).
- R3: After soft-start completes, with no trips and no supply faults, W equals floor(4*P/5).
- R4: A comparator trip present only during the first BLANK_CYC clocks of a period (default 3; clock 0 is the turn-on clock) has no effect on W.
- R5: A comparator trip that is high during blanking and still high at clock BLANK_CYC ends the pulse there, so W equals BLANK_CYC.
- R6: A trip on either comparator that first occurs at clock c >= BLANK_CYC of a period makes W = min(c, cap). The following period is unaffected.
- R7: While `por_i` is high the gate stays low from the next clock on, and the ramp is held at zero.
- R8: The ramp s starts at zero, rises by one at the end of each period with `por_i` low, and saturates at SS_END (default 32). The cap for a period is 0 when s <= SS_LO (default 9). It is floor(floor(4P/5)*(s-SS_LO)/(SS_END-SS_LO)) for values between, and floor(4P/5) when s = SS_END.
- R9: `ovp_i` high in a clock forces the gate low in the following clock. The gate output is registered, with one clock of latency from every input.
- R10: During reset, `gate_o` and `cyc_o` are low. The first period starts in the first clock after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| period_i | input | $clog2(PER_MAX+1) | Requested switching period in clocks |
| pwm_trip_i | input | 1 | Loop (PWM) comparator trip flag |
| ocp_trip_i | input | 1 | Over-current comparator trip flag |
| por_i | input | 1 | Supply power-on-reset active |
| ovp_i | input | 1 | Supply over-voltage active |
| gate_o | output | 1 | Registered gate enable |
| cyc_o | output | 1 | One-clock pulse marking each period start |

## Verification
The assertions assume that every flag input is synchronous to `clk`. They also assume that `period_i` changes only in a clock where the period counter is at zero, so no period is cut short. The stimulus drives every input on the falling edge and keeps to these assumptions. It counts the clocks from a `cyc_o` pulse, updates the period only when a new period begins, and holds `por_i` and trip windows as whole-clock levels. The bench does not need to know the expected cycle position of each trip, because it drives the inputs with respect to that same count.

// File: rtl/cmpwm_pkg.sv
package cmpwm_pkg;

  // Fixed on-time cap: DUTY_NUM/DUTY_DEN of the period.
  localparam int DUTY_NUM = 4;
  localparam int DUTY_DEN = 5;

  // Bring a requested period into the supported range.
  function automatic int clamp_period(input int req, input int lo, input int hi);
    if (req < lo) return lo;
    if (req > hi) return hi;
    return req;
  endfunction

  // Largest on-time allowed in a period of per clocks.
  function automatic int duty_cap(input int per);
    return (per * DUTY_NUM) / DUTY_DEN;
  endfunction

  // On-time allowed by the soft-start ramp at step ss.
  function automatic int ramp_limit(input int cap, input int ss, input int lo, input int hi);
    if (ss <= lo) return 0;
    if (ss >= hi) return cap;
    return (cap * (ss - lo)) / (hi - lo);
  endfunction

endpackage

// File: rtl/cmpwm_osc.sv
module cmpwm_osc #(
  parameter int PER_MIN = 20,
  parameter int PER_MAX = 100,
  parameter int PW      = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [PW-1:0] period_i,
  output logic [PW-1:0] cnt_o,
  output logic [PW-1:0] per_o,
  output logic          wrap_o
);
  import cmpwm_pkg::*;

  logic [PW-1:0] cnt_q;

  assign per_o  = PW'(clamp_period(int'(period_i), PER_MIN, PER_MAX));
  assign wrap_o = (cnt_q >= (per_o - PW'(1)));
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (wrap_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + PW'(1);
  end

  // R1: the counter never leaves the longest supported period
  p_cnt_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < PW'(PER_MAX));

  // R1: a wrap always restarts the count at zero
  p_wrap_restart_r1: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_o |=> (cnt_q == '0));

endmodule

// File: rtl/cmpwm_ramp.sv
module cmpwm_ramp #(
  parameter int SS_LO  = 9,
  parameter int SS_END = 32,
  parameter int PW     = 7,
  parameter int SW     = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          por_i,
  input  logic          wrap_i,
  input  logic [PW-1:0] per_i,
  output logic [PW-1:0] lim_o
);
  import cmpwm_pkg::*;

  logic [SW-1:0] ss_q;
  logic          ss_full;

  assign ss_full = (ss_q >= SW'(SS_END));
  assign lim_o   = PW'(ramp_limit(duty_cap(int'(per_i)), int'(ss_q), SS_LO, SS_END));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  ss_q <= '0;
    else if (por_i)              ss_q <= '0;
    else if (wrap_i && !ss_full) ss_q <= ss_q + SW'(1);
  end

  // R7: supply reset clears the ramp
  p_ss_por_r7: assert property (@(posedge clk) disable iff (!rst_n)
    por_i |=> (ss_q == '0));

  // R8: one step at the end of each period until saturation
  p_ss_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_i && !por_i && !ss_full) |=> (ss_q == $past(ss_q) + SW'(1)));

  // R8: no movement inside a period
  p_ss_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!wrap_i && !por_i) |=> $stable(ss_q));

  // R8: ramp never overshoots the end level
  p_ss_cap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ss_q <= SW'(SS_END));

endmodule

// File: rtl/cmpwm_gate.sv
module cmpwm_gate #(
  parameter int BLANK_CYC = 3,
  parameter int PW        = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [PW-1:0] cnt_i,
  input  logic          wrap_i,
  input  logic [PW-1:0] lim_i,
  input  logic          pwm_trip_i,
  input  logic          ocp_trip_i,
  input  logic          por_i,
  input  logic          ovp_i,
  output logic          gate_o,
  output logic          cyc_o
);
  localparam logic [PW-1:0] BLANK_V = PW'(BLANK_CYC);

  // Named events for the checks below.
  logic blank_win;   // leading-edge mask active
  logic trip_now;    // unmasked trip from either comparator
  logic supply_ok;   // no supply fault
  logic set_ev;      // clock edge of the set/reset pair: period start
  logic in_limit;    // on-time still below the cap
  logic killed_q;    // reset side of the set/reset pair
  logic on_d;
  logic gate_q;
  logic cyc_q;

  assign blank_win = (cnt_i < BLANK_V);
  assign trip_now  = (pwm_trip_i | ocp_trip_i) & ~blank_win;
  assign supply_ok = ~por_i & ~ovp_i;
  assign set_ev    = (cnt_i == '0);
  assign in_limit  = (cnt_i < lim_i);
  assign on_d      = supply_ok & in_limit & ~killed_q & ~trip_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      killed_q <= 1'b0;
      gate_q   <= 1'b0;
      cyc_q    <= 1'b0;
    end else begin
      if (wrap_i)        killed_q <= 1'b0;
      else if (trip_now) killed_q <= 1'b1;
      gate_q <= on_d;
      cyc_q  <= set_ev;
    end
  end

  assign gate_o = gate_q;
  assign cyc_o  = cyc_q;

  // R9: over-voltage removes the gate in the next clock
  p_ovp_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ovp_i |=> !gate_o);

  // R7: supply reset removes the gate in the next clock
  p_por_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    por_i |=> !gate_o);

  // R6: an unmasked trip on either comparator ends the pulse
  p_trip_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((cnt_i >= BLANK_V) && (pwm_trip_i || ocp_trip_i)) |=> !gate_o);

  // R4: inside the mask a running pulse is not cut by the comparators
  p_blank_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_o && (cnt_i != '0) && blank_win && (cnt_i < lim_i) && !por_i && !ovp_i)
      |=> gate_o);

  // R3: the gate is only high for counts below the cap
  p_cap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    gate_o |-> ($past(cnt_i) < $past(lim_i)));

  // R1: the period marker is a single-clock pulse
  p_cyc_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_o |=> !cyc_o);

endmodule

// File: rtl/cmpwm_core.sv
module cmpwm_core #(
  parameter int PER_MIN   = 20,
  parameter int PER_MAX   = 100,
  parameter int BLANK_CYC = 3,
  parameter int SS_LO     = 9,
  parameter int SS_END    = 32,
  localparam int PW       = $clog2(PER_MAX + 1),
  localparam int SW       = $clog2(SS_END + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [PW-1:0] period_i,
  input  logic          pwm_trip_i,
  input  logic          ocp_trip_i,
  input  logic          por_i,
  input  logic          ovp_i,
  output logic          gate_o,
  output logic          cyc_o
);
  logic [PW-1:0] cnt;
  logic [PW-1:0] per_eff;
  logic [PW-1:0] lim;
  logic          wrap;

  cmpwm_osc #(.PER_MIN(PER_MIN), .PER_MAX(PER_MAX), .PW(PW)) u_osc (
    .clk      (clk),
    .rst_n    (rst_n),
    .period_i (period_i),
    .cnt_o    (cnt),
    .per_o    (per_eff),
    .wrap_o   (wrap)
  );

  cmpwm_ramp #(.SS_LO(SS_LO), .SS_END(SS_END), .PW(PW), .SW(SW)) u_ramp (
    .clk    (clk),
    .rst_n  (rst_n),
    .por_i  (por_i),
    .wrap_i (wrap),
    .per_i  (per_eff),
    .lim_o  (lim)
  );

  cmpwm_gate #(.BLANK_CYC(BLANK_CYC), .PW(PW)) u_gate (
    .clk        (clk),
    .rst_n      (rst_n),
    .cnt_i      (cnt),
    .wrap_i     (wrap),
    .lim_i      (lim),
    .pwm_trip_i (pwm_trip_i),
    .ocp_trip_i (ocp_trip_i),
    .por_i      (por_i),
    .ovp_i      (ovp_i),
    .gate_o     (gate_o),
    .cyc_o      (cyc_o)
  );

  // R3: the cap handed to the gate never exceeds four fifths of the period
  p_lim_cap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(lim) * 5) <= (int'(per_eff) * 4));

endmodule

// File: tb/cmpwm_core_tb.sv
module cmpwm_core_tb;
  localparam int CLK_PERIOD = 10;
  localparam int PMIN = 20, PMAX = 100, BLK = 3, SLO = 9, SEND = 32;
  localparam int PW = $clog2(PMAX + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [PW-1:0] period_i = PW'(50);
  logic pwm_trip_i = 1'b0, ocp_trip_i = 1'b0, por_i = 1'b1, ovp_i = 1'b0;
  logic gate_o, cyc_o;

  int checks = 0, errors = 0;
  bit done = 1'b0, mon_on = 1'b0;
  int ss_m = 0;
  int per_req = 50;
  int qw[$];
  int ql[$];
  string qr[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  cmpwm_core #(.PER_MIN(PMIN), .PER_MAX(PMAX), .BLANK_CYC(BLK),
               .SS_LO(SLO), .SS_END(SEND)) u_dut (
    .clk(clk), .rst_n(rst_n), .period_i(period_i),
    .pwm_trip_i(pwm_trip_i), .ocp_trip_i(ocp_trip_i),
    .por_i(por_i), .ovp_i(ovp_i), .gate_o(gate_o), .cyc_o(cyc_o));

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // One period, entered at the falling edge where the count is zero.
  // src: 0 none, 1 loop comparator, 2 over-current comparator.
  task automatic run_period(input string req, input int src, input int t_on,
                            input int t_off, input int ovp_from, input bit por);
    int p, cap, lim, w;
    bit killed;
    p = (per_req < PMIN) ? PMIN : ((per_req > PMAX) ? PMAX : per_req);
    cap = (4 * p) / 5;
    if (ss_m <= SLO) lim = 0;
    else if (ss_m >= SEND) lim = cap;
    else lim = cap * (ss_m - SLO) / (SEND - SLO);
    w = 0; killed = 1'b0;
    for (int c = 0; c < p; c++) begin
      bit trip, tn, ok;
      trip = (src != 0) && (c >= t_on) && (c < t_off);
      tn = trip && (c >= BLK);
      ok = !por && (c < ovp_from);
      if (ok && (c < lim) && !killed && !tn) w++;
      if (tn) killed = 1'b1;
    end
    qw.push_back(w); ql.push_back(p); qr.push_back(req);
    mon_on = 1'b1;
    period_i = PW'(per_req);
    for (int c = 0; c < p; c++) begin
      pwm_trip_i = (src == 1) && (c >= t_on) && (c < t_off);
      ocp_trip_i = (src == 2) && (c >= t_on) && (c < t_off);
      ovp_i = (c >= ovp_from);
      por_i = por;
      @(negedge clk);
    end
    if (por) ss_m = 0;
    else if (ss_m < SEND) ss_m++;
  endtask

  // Monitor: measures each period window from one cyc_o pulse to the next.
  initial begin
    bit open = 1'b0;
    int wcnt = 0, lcnt = 0;
    forever begin
      @(negedge clk);
      if (mon_on && cyc_o) begin
        if (open) begin
          if (qw.size() == 0) begin
            check("R1 unexpected period", 1, 0);
          end else begin
            int ew, el;
            string r;
            ew = qw.pop_front(); el = ql.pop_front(); r = qr.pop_front();
            check({r, " width"}, wcnt, ew);
            check("R1 period length", lcnt, el);
          end
        end
        open = 1'b1; wcnt = int'(gate_o); lcnt = 1;
      end else if (open) begin
        wcnt += int'(gate_o); lcnt++;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R10 gate low in reset", int'(gate_o), 0);
    check("R10 cyc low in reset", int'(cyc_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 first period starts", int'(cyc_o), 1);
    repeat (49) @(negedge clk);   // count back at zero

    // R7: supply reset holds gate off and ramp at zero
    repeat (2) run_period("R7 por", 0, 0, 0, 1000, 1'b1);
    // R8: ramp from zero to the end level, R3 at full cap
    for (int k = 0; k < 34; k++) run_period("R8 ramp", 0, 0, 0, 1000, 1'b0);
    run_period("R3 full cap", 0, 0, 0, 1000, 1'b0);
    // R6: trips after blanking, both comparators
    run_period("R6 pwm trip", 1, 20, 1000, 1000, 1'b0);
    run_period("R6 next unaffected", 0, 0, 0, 1000, 1'b0);
    run_period("R6 ocp trip", 2, 25, 1000, 1000, 1'b0);
    // R4: trips only inside blanking are ignored
    run_period("R4 ocp in blank", 2, 1, 2, 1000, 1'b0);
    run_period("R4 pwm in blank", 1, 0, 3, 1000, 1'b0);
    // R5: trip spanning the end of blanking
    run_period("R5 pwm held", 1, 0, 10, 1000, 1'b0);
    run_period("R5 ocp held", 2, 1, 5, 1000, 1'b0);
    // R9: supply over-voltage
    run_period("R9 ovp whole", 0, 0, 0, 0, 1'b0);
    run_period("R9 ovp mid", 0, 0, 0, 15, 1'b0);
    run_period("R9 recovered", 0, 0, 0, 1000, 1'b0);
    // R1/R3: period programming and clamping
    per_req = 100; run_period("R1 long period", 0, 0, 0, 1000, 1'b0);
    per_req = 120; run_period("R1 clamp high", 0, 0, 0, 1000, 1'b0);
    per_req = 5;   run_period("R1 clamp low", 0, 0, 0, 1000, 1'b0);
    run_period("R6 short period trip", 2, 7, 1000, 1000, 1'b0);
    per_req = 50;  run_period("R2 back to 50", 0, 0, 0, 1000, 1'b0);
    // R7/R8: supply reset mid run restarts the ramp
    run_period("R7 por again", 0, 0, 0, 1000, 1'b1);
    for (int k = 0; k < 14; k++) run_period("R8 re-ramp", 0, 0, 0, 1000, 1'b0);

    @(negedge clk);  // closes the last window
    mon_on = 1'b0;
    check("R2 all periods observed", qw.size(), 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule